// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out block stack instructions that copy a contiguous run of general registers to memory (push) or back from memory (pop). Any of the eight registers can serve as the stack pointer. A decoded instruction word is presented with a one-cycle `start` strobe. The sequencer then reads the chosen pointer register and moves one 16-bit word per clock through a single-port memory interface. The register file is reached through one combinational read port and one write port. At the end it writes the updated pointer back and pulses `done`.

The stack grows toward lower addresses. A push stores at the pointer and then decrements it, beginning with the highest-numbered register. A pop pre-increments the pointer and reads, beginning with the lowest-numbered register, so a pop of the same range undoes a push. Two pop encodings serve as subroutine and interrupt returns. They restore the status and program-counter registers, and the interrupt return also restores a third word into an interrupt-flag register kept inside the block. Encodings that are not stack instructions, and ranges that fall outside the register file, raise `illegal` and move nothing.

Memory reads are asynchronous: `mem_rdata` reflects `mem_addr` in the same cycle. The external `rst_n` is asynchronous and active low. The block releases its internal reset two clocks after `rst_n` rises.

Top module: `stack_burst_unit`

## Requirements
- R1: The instruction word has these fields: bits [15:12] major opcode, [11:9] range field A, [8:6] mode, [5:3] count N, [2:0] pointer register. Mode 2 with major opcode 4'h9 is a pop, and mode 2 with major opcode 4'hD is a push. Any other word given with `start` makes `illegal` high for exactly the next cycle, with `busy` low and no memory or register write.
- R2: An accepted instruction holds `busy` high from the cycle after `start` through the `done` cycle. That is N+2 cycles: one pointer-read cycle, N transfer cycles and one write-back cycle. `done` is high for that last cycle only.
- R3: In push transfer k (k = 0..N-1), register A+1-k is written to address P-k with `mem_we` high, where P is the pointer register's value at the start.
- R4: In pop transfer k, the word at address P+1+k is written into register A+1+k, and `mem_we` stays low.
- R5: In the `done` cycle the register write port writes P-N (push) or P+N (pop) into the pointer register. This is the last write, so it takes precedence over a value popped into the same register.
- R6: A push with A = 7 or N > A+1 is illegal. A pop with A+N > 7 is illegal, except the form in R7. Both behave as in R1.
- R7: A pop with A = 5, N = 3 and pointer register 0 restores registers 6 and 7 and puts the third word on `iflags` instead of writing the register file. A pop with A = 5, N = 2 and pointer register 0 restores registers 6 and 7 only.
- R8: N = 0 moves no word. The pointer is written back unchanged and `done` comes two cycles after `start`.
- R9: `start` while `busy` is high is ignored. The running sequence continues unchanged and `illegal` stays low.
- R10: During and right after reset, `busy`, `done`, `illegal`, `mem_we` and `rf_we` are low and `iflags` is zero. `iflags` changes only while `busy` is high.
- R11: A push followed by a pop of the same range with the same pointer register restores every register of the range and the pointer's original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction strobe, taken when idle |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse, coincides with pointer write-back |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data for `mem_addr` |
| iflags | output | 16 | Interrupt-flag word restored by the interrupt return |

## Verification
A wrong transfer index or direction shows up in the first transfer cycle, on `mem_addr`, on `rf_waddr`, or as a word stored under the wrong register. A miscounted length moves `done` by a cycle and leaves the pointer write-back off by the same amount. Both are caught in the cycle they occur, because every output is compared on every clock. Errors in the range check or the return forms appear at once as an `illegal` pulse or a missing `busy`, or as `iflags` failing to change. A broken stack order is exposed by the push-then-pop round trip, which checks the final register contents.

// File: rtl/stkb_pkg.sv
package stkb_pkg;

  localparam int INSTR_W = 16;
  localparam int REG_IW  = 3;
  localparam int CNT_W   = 3;
  localparam int NREGS   = 1 << REG_IW;

  localparam logic [3:0] OPC_POP   = 4'h9;
  localparam logic [3:0] OPC_PUSH  = 4'hD;
  localparam logic [2:0] MODE_STK  = 3'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_XFER = 2'd2,
    ST_WB   = 2'd3
  } stkb_state_e;

  typedef struct packed {
    logic              legal;
    logic              is_push;
    logic [REG_IW:0]   first_reg;
    logic [CNT_W-1:0]  count;
    logic [REG_IW-1:0] ptr_reg;
  } stkb_dec_t;

endpackage

// File: rtl/stkb_decode.sv
module stkb_decode
  import stkb_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output stkb_dec_t          dec_o
);

  logic [3:0]        op_major;
  logic [2:0]        fld_a;
  logic [2:0]        fld_mode;
  logic [CNT_W-1:0]  fld_n;
  logic [REG_IW-1:0] fld_ptr;
  logic              hit_pop;
  logic              hit_push;
  logic              ret_int;
  logic              pop_fits;
  logic              push_fits;
  logic [4:0]        pop_top;

  always_comb begin
    op_major = instr_i[15:12];
    fld_a    = instr_i[11:9];
    fld_mode = instr_i[8:6];
    fld_n    = instr_i[5:3];
    fld_ptr  = instr_i[2:0];

    hit_pop  = (fld_mode == MODE_STK) && (op_major == OPC_POP);
    hit_push = (fld_mode == MODE_STK) && (op_major == OPC_PUSH);

    // interrupt return: range runs one past the last register into the flag word
    ret_int  = hit_pop && (fld_a == 3'd5) && (fld_n == 3'd3) && (fld_ptr == '0);

    pop_top   = {2'b00, fld_a} + {2'b00, fld_n};
    pop_fits  = (pop_top <= 5'd7) || ret_int;
    push_fits = (fld_a <= 3'd6) && ({1'b0, fld_n} <= ({1'b0, fld_a} + 4'd1));

    dec_o.legal     = (hit_pop && pop_fits) || (hit_push && push_fits);
    dec_o.is_push   = hit_push;
    dec_o.first_reg = {1'b0, fld_a} + 4'd1;
    dec_o.count     = fld_n;
    dec_o.ptr_reg   = fld_ptr;
  end

endmodule

// File: rtl/stkb_ctrl.sv
module stkb_ctrl
  import stkb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  stkb_dec_t         dec_i,
  output stkb_state_e       state_o,
  output logic              push_o,
  output logic [REG_IW-1:0] ptr_reg_o,
  output logic [REG_IW:0]   cur_reg_o,
  output logic              illegal_o
);

  stkb_state_e       state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_IW:0]   first_q;
  logic              push_q;
  logic [REG_IW-1:0] preg_q;
  logic              ill_q, ill_d;
  logic              accept;
  logic              idx_en;

  assign accept = (state_q == ST_IDLE) && start_i && dec_i.legal;
  assign idx_en = (state_q == ST_PTR) || (state_q == ST_XFER);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ill_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (dec_i.legal) state_d = ST_PTR;
          else             ill_d   = 1'b1;
        end
      end
      ST_PTR: begin
        idx_d   = '0;
        state_d = (cnt_q == '0) ? ST_WB : ST_XFER;
      end
      ST_XFER: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == (cnt_q - 1'b1)) state_d = ST_WB;
      end
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= '0;
      push_q  <= 1'b0;
      preg_q  <= '0;
    end else if (accept) begin
      cnt_q   <= dec_i.count;
      first_q <= dec_i.first_reg;
      push_q  <= dec_i.is_push;
      preg_q  <= dec_i.ptr_reg;
    end
  end

  assign state_o   = state_q;
  assign push_o    = push_q;
  assign ptr_reg_o = preg_q;
  assign illegal_o = ill_q;
  assign cur_reg_o = push_q ? (first_q - {1'b0, idx_q}) : (first_q + {1'b0, idx_q});

endmodule

// File: rtl/stkb_ptr.sv
module stkb_ptr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              dir_push_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;
  logic [ADDR_W-1:0] sp_inc;
  logic [ADDR_W-1:0] sp_dec;

  assign sp_inc = sp_q + 1'b1;
  assign sp_dec = sp_q - 1'b1;
  assign sp_en  = load_i || step_i;

  always_comb begin
    if (load_i)          sp_d = ADDR_W'(rdata_i);
    else if (dir_push_i) sp_d = sp_dec;
    else                 sp_d = sp_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  assign sp_o   = sp_q;
  assign addr_o = dir_push_i ? sp_q : sp_inc;

endmodule

// File: rtl/stack_burst_unit.sv
module stack_burst_unit
  import stkb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [INSTR_W-1:0]   instr,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal,
  output logic [REG_IW-1:0]    rf_raddr,
  input  logic [DATA_W-1:0]    rf_rdata,
  output logic                 rf_we,
  output logic [REG_IW-1:0]    rf_waddr,
  output logic [DATA_W-1:0]    rf_wdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic                 mem_we,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    iflags
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  stkb_dec_t         dec;
  stkb_state_e       state;
  logic              push;
  logic [REG_IW-1:0] ptr_reg;
  logic [REG_IW:0]   cur_reg;
  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] xfer_addr;
  logic              in_xfer;
  logic              in_wb;
  logic              flag_slot;
  logic              flag_en;
  logic [DATA_W-1:0] iflags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  stkb_decode u_dec (
    .instr_i (instr),
    .dec_o   (dec)
  );

  stkb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .dec_i     (dec),
    .state_o   (state),
    .push_o    (push),
    .ptr_reg_o (ptr_reg),
    .cur_reg_o (cur_reg),
    .illegal_o (illegal)
  );

  assign in_xfer   = (state == ST_XFER);
  assign in_wb     = (state == ST_WB);
  assign flag_slot = cur_reg[REG_IW];

  stkb_ptr #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (state == ST_PTR),
    .step_i     (in_xfer),
    .dir_push_i (push),
    .rdata_i    (rf_rdata),
    .sp_o       (sp),
    .addr_o     (xfer_addr)
  );

  assign flag_en = in_xfer && !push && flag_slot;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      iflags_q <= '0;
    end else if (flag_en) begin
      iflags_q <= mem_rdata;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = in_wb;
  assign rf_raddr  = (state == ST_PTR) ? ptr_reg : cur_reg[REG_IW-1:0];
  assign mem_addr  = xfer_addr;
  assign mem_wdata = rf_rdata;
  assign mem_we    = in_xfer && push;
  assign rf_we     = (in_xfer && !push && !flag_slot) || in_wb;
  assign rf_waddr  = in_wb ? ptr_reg : cur_reg[REG_IW-1:0];
  assign rf_wdata  = in_wb ? DATA_W'(sp) : mem_rdata;
  assign iflags    = iflags_q;

endmodule

// File: rtl/stkb_checker.sv
module stkb_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              rf_we,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] iflags
);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R3
  push_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

  // R3
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5
  done_writes_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rf_we && !mem_we));

  // R6
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !rf_we && !mem_we));

  // R9
  start_busy_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> !illegal);

  // R10
  iflags_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(iflags));

endmodule

bind stack_burst_unit stkb_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_stkb_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .rf_we    (rf_we),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .iflags   (iflags)
);

// File: tb/stack_burst_unit_bench.sv
module stack_burst_unit_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          busy;
    bit          done;
    bit          ill;
    bit          mwe;
    bit          chka;
    logic [15:0] maddr;
    logic [15:0] mwdata;
    bit          rwe;
    logic [2:0]  rwa;
    logic [15:0] rwd;
    bit          iset;
    logic [15:0] ival;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, illegal, rf_we, mem_we;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, iflags;

  logic [15:0] rf  [0:7];
  logic [15:0] mem [0:255];

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  exp_t expq[$];
  string tagq[$];
  logic [15:0] exp_ifl = '0;

  bit          pend_rwe = 0, pend_mwe = 0;
  logic [2:0]  pend_rwa;
  logic [15:0] pend_rwd, pend_ma, pend_md;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:0]];

  stack_burst_unit u_stack_burst_unit (
    .clk (clk), .rst_n (rst_n), .start (start), .instr (instr),
    .busy (busy), .done (done), .illegal (illegal),
    .rf_raddr (rf_raddr), .rf_rdata (rf_rdata), .rf_we (rf_we),
    .rf_waddr (rf_waddr), .rf_wdata (rf_wdata),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we),
    .mem_rdata (mem_rdata), .iflags (iflags)
  );

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] a,
                                      input logic [2:0] md, input logic [2:0] n,
                                      input logic [2:0] p);
    return {op, a, md, n, p};
  endfunction

  function automatic exp_t blank();
    exp_t e;
    e.busy = 0; e.done = 0; e.ill = 0; e.mwe = 0; e.chka = 0;
    e.maddr = '0; e.mwdata = '0; e.rwe = 0; e.rwa = '0; e.rwd = '0;
    e.iset = 0; e.ival = '0;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // behavioural model: builds the expected per-cycle outputs of one instruction
  task automatic model(input logic [15:0] ins, input string badtag);
    int op = ins[15:12], a = ins[11:9], md = ins[8:6], n = ins[5:3], p = ins[2:0];
    bit is_pop  = (md == 2) && (op == 9);
    bit is_push = (md == 2) && (op == 13);
    bit reti    = is_pop && a == 5 && n == 3 && p == 0;
    bit ok      = (is_pop && ((a + n <= 7) || reti)) || (is_push && a <= 6 && n <= a + 1);
    exp_t e;
    logic [15:0] ptr;
    if (!ok) begin
      e = blank(); e.ill = 1; expq.push_back(e); tagq.push_back(badtag);
      return;
    end
    ptr = rf[p];
    e = blank(); e.busy = 1; expq.push_back(e); tagq.push_back("R2");
    for (int k = 0; k < n; k++) begin
      e = blank(); e.busy = 1;
      if (is_push) begin
        e.mwe = 1; e.maddr = ptr - 16'(k); e.mwdata = rf[a + 1 - k];
        expq.push_back(e); tagq.push_back("R3");
      end else begin
        e.chka = 1; e.maddr = ptr + 16'(k + 1);
        if (a + 1 + k == 8) begin
          e.iset = 1; e.ival = mem[e.maddr[7:0]];
          expq.push_back(e); tagq.push_back("R7");
        end else begin
          e.rwe = 1; e.rwa = 3'(a + 1 + k); e.rwd = mem[e.maddr[7:0]];
          expq.push_back(e); tagq.push_back(reti ? "R7" : "R4");
        end
      end
    end
    e = blank(); e.busy = 1; e.done = 1; e.rwe = 1; e.rwa = 3'(p);
    e.rwd = is_push ? ptr - 16'(n) : ptr + 16'(n);
    expq.push_back(e); tagq.push_back(n == 0 ? "R8" : "R5");
  endtask

  task automatic step();
    exp_t e;
    string tag;
    bit ok;
    @(negedge clk);
    if (pend_rwe) rf[pend_rwa] = pend_rwd;
    if (pend_mwe) mem[pend_ma[7:0]] = pend_md;
    start = 1'b0;
    if (expq.size() > 0) begin
      e = expq.pop_front(); tag = tagq.pop_front();
    end else begin
      e = blank(); tag = "R2";
    end
    ok = (busy == e.busy) && (done == e.done) && (illegal == e.ill) &&
         (mem_we == e.mwe) && (rf_we == e.rwe) && (iflags == exp_ifl);
    if (e.mwe)  ok = ok && (mem_addr == e.maddr) && (mem_wdata == e.mwdata);
    if (e.chka) ok = ok && (mem_addr == e.maddr);
    if (e.rwe)  ok = ok && (rf_waddr == e.rwa) && (rf_wdata == e.rwd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual busy=%0b done=%0b ill=%0b mwe=%0b ma=%h md=%h rwe=%0b ra=%0d rd=%h fl=%h expected busy=%0b done=%0b ill=%0b mwe=%0b ma=%h md=%h rwe=%0b ra=%0d rd=%h fl=%h",
               tag, busy, done, illegal, mem_we, mem_addr, mem_wdata, rf_we, rf_waddr, rf_wdata, iflags,
               e.busy, e.done, e.ill, e.mwe, e.maddr, e.mwdata, e.rwe, e.rwa, e.rwd, exp_ifl);
    end
    if (e.iset) exp_ifl = e.ival;
    pend_rwe = rf_we; pend_rwa = rf_waddr; pend_rwd = rf_wdata;
    pend_mwe = mem_we; pend_ma = mem_addr; pend_md = mem_wdata;
  endtask

  task automatic issue(input logic [15:0] ins, input string badtag);
    if (expq.size() == 0) model(ins, badtag);
    instr = ins;
    start = 1'b1;
    step();
  endtask

  task automatic drain();
    while (expq.size() > 0) step();
    step();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 16'h1000 * 16'(i) + 16'h0011;
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
    repeat (3) @(negedge clk);
    // R10: outputs held low during reset
    check(!busy && !done && !illegal && !mem_we && !rf_we, "R10", {11'b0, busy, done, illegal, mem_we, rf_we}, 16'h0);
    check(iflags == 16'h0, "R10", iflags, 16'h0);
    rst_n = 1'b1;
    repeat (4) step();

    // R3: push registers 4..2 through pointer R1
    rf[1] = 16'h0080;
    issue(enc(4'hD, 3'd3, 3'd2, 3'd3, 3'd1), "R6");
    drain();
    check(mem[8'h80] == 16'h4011 && mem[8'h7E] == 16'h2011, "R3", mem[8'h7E], 16'h2011);
    // R11: clobber, then pop the same range back
    rf[2] = 16'hDEAD; rf[3] = 16'hBEEF; rf[4] = 16'hCAFE;
    issue(enc(4'h9, 3'd1, 3'd2, 3'd3, 3'd1), "R6");
    drain();
    check(rf[2] == 16'h2011 && rf[3] == 16'h3011, "R11", rf[3], 16'h3011);
    check(rf[4] == 16'h4011, "R11", rf[4], 16'h4011);
    check(rf[1] == 16'h0080, "R11", rf[1], 16'h0080);

    // R8: empty count
    issue(enc(4'hD, 3'd2, 3'd2, 3'd0, 3'd5), "R6");
    drain();
    check(rf[5] == 16'h5011, "R8", rf[5], 16'h5011);

    // R1: wrong major opcode and wrong mode
    issue(enc(4'h5, 3'd1, 3'd2, 3'd2, 3'd0), "R1");
    drain();
    issue(enc(4'h9, 3'd1, 3'd3, 3'd2, 3'd0), "R1");
    drain();
    // R6: out-of-range ranges
    issue(enc(4'hD, 3'd7, 3'd2, 3'd1, 3'd0), "R6");
    drain();
    issue(enc(4'hD, 3'd2, 3'd2, 3'd4, 3'd0), "R6");
    drain();
    issue(enc(4'h9, 3'd4, 3'd2, 3'd4, 3'd0), "R6");
    drain();
    issue(enc(4'h9, 3'd5, 3'd2, 3'd3, 3'd1), "R6");
    drain();
    check(rf[6] == 16'h6011 && rf[7] == 16'h7011, "R6", rf[6], 16'h6011);

    // R7: subroutine return through R0
    rf[0] = 16'h0040; mem[8'h41] = 16'h0123; mem[8'h42] = 16'h4567;
    issue(enc(4'h9, 3'd5, 3'd2, 3'd2, 3'd0), "R6");
    drain();
    check(rf[6] == 16'h0123 && rf[7] == 16'h4567, "R7", rf[7], 16'h4567);
    check(rf[0] == 16'h0042, "R7", rf[0], 16'h0042);
    // R7: interrupt return restores the flag word
    rf[0] = 16'h0050; mem[8'h51] = 16'h0777; mem[8'h52] = 16'h0888; mem[8'h53] = 16'h00C3;
    issue(enc(4'h9, 3'd5, 3'd2, 3'd3, 3'd0), "R6");
    drain();
    check(iflags == 16'h00C3, "R7", iflags, 16'h00C3);
    check(rf[0] == 16'h0053 && rf[7] == 16'h0888, "R7", rf[0], 16'h0053);

    // R5: pointer inside the popped range, write-back wins
    rf[2] = 16'h0030;
    issue(enc(4'h9, 3'd0, 3'd2, 3'd3, 3'd2), "R6");
    drain();
    check(rf[2] == 16'h0033, "R5", rf[2], 16'h0033);
    check(rf[1] == mem[8'h31] && rf[3] == mem[8'h33], "R4", rf[3], mem[8'h33]);

    // R9: full push with pointer R7, second start while busy
    rf[7] = 16'h00C0;
    issue(enc(4'hD, 3'd6, 3'd2, 3'd7, 3'd7), "R6");
    step(); step();
    issue(enc(4'h5, 3'd0, 3'd0, 3'd0, 3'd0), "R9");
    issue(enc(4'h9, 3'd1, 3'd2, 3'd1, 3'd1), "R9");
    drain();
    check(rf[7] == 16'h00B9, "R9", rf[7], 16'h00B9);
    check(mem[8'hC0] == 16'h00C0 && mem[8'hBA] == rf[1], "R3", mem[8'hBA], rf[1]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule